// File: doc/BRIEF.md
# Prioritized CAN Transmit Message Scheduler

This block decides which outgoing CAN frame is handed to the protocol engine next. Frames come in through a host write port and go into one of two stores. The first is an ordinary transmit queue whose depth is set by a parameter. The second is a one-entry urgent slot. Whenever the engine is free and a frame is pending, the block raises a request and shows the chosen frame. The urgent slot always wins over the queue head.

The engine accepts a frame with a grant. Later it reports the outcome with a done strobe and a two-bit result code. A successful outcome releases the frame from its store. Any other outcome (bit error, form error, lost arbitration) leaves the frame where it was, so it is offered again automatically. A frame already handed to the engine is never withdrawn. The block also provides occupancy flags, a sticky overflow flag for dropped writes, a completion pulse, and a host abort for an urgent frame that has not yet started.

Top module: `can_tx_sched`

## Requirements
- R1: While reset (active-low `rst_n`) is held, the outputs read `fifo_empty`=1, `fifo_full`=0, `hp_busy`=0, `ovf_flag`=0, `eng_req`=0 and `tx_done`=0.
- R2: Queue frames are offered in write order. The queue head is removed only by a done report whose result is 00 (success).
- R3: A write is dropped and sets `ovf_flag` in the following cycle in two cases: a queue write (`wr_to_hp`=0) while the queue is full at the start of that cycle, or an urgent write (`wr_to_hp`=1) while the urgent slot is occupied. `ovf_flag` then stays 1 until reset.
- R4: While no frame is in flight and the urgent slot is occupied, the offered frame is the urgent one (`eng_hp`=1), whatever the queue holds.
- R5: A frame in flight is not pre-empted when the urgent slot fills. `eng_req` stays 0 until the engine's done report ends that attempt.
- R6: A done report with result 01 (bit error), 10 (form error) or 11 (arbitration lost) leaves the frame in its store. In the next cycle it is offered again with the same contents, unless an urgent frame now takes precedence over a queue frame.
- R7: `tx_done` is high for exactly one cycle, in the cycle after each done report with result 00.
- R8: `hp_abort` empties the urgent slot in the next cycle when the urgent frame is not in flight and is not being granted in the same cycle. Otherwise it has no effect.
- R9: `fifo_empty` is 1 exactly when the queue holds no frame. `fifo_full` is 1 exactly when it holds DEPTH frames. `hp_busy` is 1 exactly when the urgent slot is occupied.
- R10: `eng_req` is 1 exactly when no frame is in flight and a frame is pending. A grant while `eng_req`=0 is ignored, and a done report while no frame is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Host write strobe |
| wr_to_hp | input | 1 | 1 selects the urgent slot, 0 the queue |
| wr_id | input | 29 | Frame identifier |
| wr_ext | input | 1 | Extended-format flag |
| wr_dlc | input | 4 | Length code |
| wr_data | input | 64 | Payload bytes |
| hp_abort | input | 1 | Cancel the urgent frame if not started |
| eng_req | output | 1 | A frame is offered to the engine |
| eng_hp | output | 1 | Offered or in-flight frame is the urgent one |
| eng_id | output | 29 | Offered frame identifier |
| eng_ext | output | 1 | Offered frame format flag |
| eng_dlc | output | 4 | Offered frame length code |
| eng_data | output | 64 | Offered frame payload |
| eng_grant | input | 1 | Engine takes the offered frame |
| eng_done | input | 1 | Engine reports the end of an attempt |
| eng_result | input | 2 | 00 ok, 01 bit error, 10 form error, 11 arbitration lost |
| fifo_empty | output | 1 | Queue holds no frame |
| fifo_full | output | 1 | Queue holds DEPTH frames |
| hp_busy | output | 1 | Urgent slot occupied |
| ovf_flag | output | 1 | Sticky flag for a dropped write |
| tx_done | output | 1 | One-cycle pulse per successful frame |

## Verification
Some properties are local and are checked by assertions on every cycle. A granted offer is withdrawn in the next cycle. An occupied urgent slot always wins the offer. The overflow flag never falls. The completion pulse never lasts two cycles. The two queue flags never hold together. Other behaviour spans several cycles and only the bench's scenarios can show it: write ordering through the queue, retries that keep the same frame after each kind of failure, the urgent frame waiting behind an in-flight queue frame, and abort taking effect before the grant but not after it. The bench's reference model follows all of these cycle by cycle.

// File: rtl/can_tx_sched_pkg.sv
// Shared types for the transmit scheduler: the frame record and the
// engine result codes. Assumes 29-bit identifiers and 8 payload bytes.
package can_tx_sched_pkg;
    localparam int ID_W   = 29;
    localparam int DLC_W  = 4;
    localparam int DATA_W = 64;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic              ext;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } can_msg_t;

    typedef enum logic [1:0] {
        RES_OK       = 2'b00,
        RES_BIT_ERR  = 2'b01,
        RES_FORM_ERR = 2'b10,
        RES_ARB_LOST = 2'b11
    } tx_result_e;
endpackage

// File: rtl/can_tx_msg_fifo.sv
// Circular frame queue of DEPTH entries (2..63). A push is refused when
// the queue is full at the start of the cycle. Assumes pop is asserted
// only while not empty.
module can_tx_msg_fifo
    import can_tx_sched_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push_req,
    input  can_msg_t push_msg,
    input  logic     pop,
    output can_msg_t head,
    output logic     empty,
    output logic     full,
    output logic     push_drop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    can_msg_t         mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             accept;

    assign empty     = (count == '0);
    assign full      = (count == CNT_W'(DEPTH));
    assign accept    = push_req && !full;
    assign push_drop = push_req && full;
    assign head      = mem[rd_ptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= push_msg;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)    rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({accept, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/can_tx_hp_slot.sv
// One-entry urgent frame holder. A load is refused while occupied;
// clear empties it. Assumes clear is only asserted while occupied.
module can_tx_hp_slot
    import can_tx_sched_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  can_msg_t load_msg,
    input  logic     clear,
    output logic     valid,
    output can_msg_t msg,
    output logic     load_drop
);
    assign load_drop = load && valid;

    // Occupancy flag.
    always_ff @(posedge clk) begin
        if (!rst_n)              valid <= 1'b0;
        else if (clear)          valid <= 1'b0;
        else if (load && !valid) valid <= 1'b1;
    end

    // Frame contents, captured on an accepted load.
    always_ff @(posedge clk) begin
        if (load && !valid) msg <= load_msg;
    end
endmodule

// File: rtl/can_tx_arbiter.sv
// Transmit attempt controller: offers a frame when idle (urgent first),
// tracks the in-flight source and turns done reports into releases or
// retries. Assumes the engine raises done only for a granted frame.
module can_tx_arbiter
    import can_tx_sched_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hp_valid,
    input  logic fifo_empty,
    input  logic eng_grant,
    input  logic eng_done,
    input  logic [1:0] eng_result,
    output logic eng_req,
    output logic eng_hp,
    output logic hp_locked,
    output logic fifo_pop,
    output logic hp_sent,
    output logic tx_done
);
    logic busy, src_hp, finish, ok, take;

    assign eng_req   = !busy && (hp_valid || !fifo_empty);
    assign eng_hp    = busy ? src_hp : hp_valid;
    assign take      = eng_req && eng_grant;
    assign finish    = busy && eng_done;
    assign ok        = finish && (tx_result_e'(eng_result) == RES_OK);
    assign fifo_pop  = ok && !src_hp;
    assign hp_sent   = ok && src_hp;
    assign hp_locked = (busy && src_hp) || (take && hp_valid);

    // Attempt state: idle/in-flight, source, completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            src_hp  <= 1'b0;
            tx_done <= 1'b0;
        end else begin
            tx_done <= ok;
            if (take) begin
                busy   <= 1'b1;
                src_hp <= hp_valid;
            end else if (finish) begin
                busy   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/can_tx_sched.sv
// Top of the prioritized transmit scheduler: host write port, queue,
// urgent slot, attempt controller, overflow flag. Single clock,
// synchronous active-low reset.
module can_tx_sched
    import can_tx_sched_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_to_hp,
    input  logic [ID_W-1:0]   wr_id,
    input  logic              wr_ext,
    input  logic [DLC_W-1:0]  wr_dlc,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              hp_abort,
    output logic              eng_req,
    output logic              eng_hp,
    output logic [ID_W-1:0]   eng_id,
    output logic              eng_ext,
    output logic [DLC_W-1:0]  eng_dlc,
    output logic [DATA_W-1:0] eng_data,
    input  logic              eng_grant,
    input  logic              eng_done,
    input  logic [1:0]        eng_result,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              hp_busy,
    output logic              ovf_flag,
    output logic              tx_done
);
    can_msg_t wr_msg, fifo_head, hp_msg, sel_msg;
    logic fifo_drop, hp_drop, hp_locked, fifo_pop, hp_sent, hp_clear;

    assign wr_msg   = '{id: wr_id, ext: wr_ext, dlc: wr_dlc, data: wr_data};
    assign hp_clear = hp_sent || (hp_abort && hp_busy && !hp_locked);
    assign sel_msg  = eng_hp ? hp_msg : fifo_head;
    assign eng_id   = sel_msg.id;
    assign eng_ext  = sel_msg.ext;
    assign eng_dlc  = sel_msg.dlc;
    assign eng_data = sel_msg.data;

    can_tx_msg_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_req(wr_valid && !wr_to_hp), .push_msg(wr_msg),
        .pop(fifo_pop), .head(fifo_head),
        .empty(fifo_empty), .full(fifo_full), .push_drop(fifo_drop)
    );

    can_tx_hp_slot u_hp (
        .clk(clk), .rst_n(rst_n),
        .load(wr_valid && wr_to_hp), .load_msg(wr_msg),
        .clear(hp_clear), .valid(hp_busy), .msg(hp_msg),
        .load_drop(hp_drop)
    );

    can_tx_arbiter u_arb (
        .clk(clk), .rst_n(rst_n),
        .hp_valid(hp_busy), .fifo_empty(fifo_empty),
        .eng_grant(eng_grant), .eng_done(eng_done), .eng_result(eng_result),
        .eng_req(eng_req), .eng_hp(eng_hp), .hp_locked(hp_locked),
        .fifo_pop(fifo_pop), .hp_sent(hp_sent), .tx_done(tx_done)
    );

    // Sticky overflow flag, set by any refused write.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ovf_flag <= 1'b0;
        else if (fifo_drop || hp_drop) ovf_flag <= 1'b1;
    end
endmodule

// File: rtl/can_tx_sched_chk.sv
// Property checker for the transmit scheduler, bound to every instance.
module can_tx_sched_chk (
    input logic clk,
    input logic rst_n,
    input logic eng_req,
    input logic eng_grant,
    input logic eng_hp,
    input logic hp_busy,
    input logic fifo_empty,
    input logic fifo_full,
    input logic ovf_flag,
    input logic tx_done
);
    assert_grant_withdraws_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_grant) |=> !eng_req);

    assert_urgent_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && hp_busy) |-> eng_hp);

    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_empty && fifo_full));
endmodule

bind can_tx_sched can_tx_sched_chk u_chk (
    .clk(clk), .rst_n(rst_n), .eng_req(eng_req), .eng_grant(eng_grant),
    .eng_hp(eng_hp), .hp_busy(hp_busy), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .ovf_flag(ovf_flag), .tx_done(tx_done)
);

// File: tb/can_tx_sched_bench.sv
// Bench: behavioural reference model (queue + flags) compared every cycle,
// plus named scenario checks.
module can_tx_sched_bench;
    localparam int DEPTH = 4;
    localparam int MW    = 98;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 0, wr_to_hp = 0, hp_abort = 0;
    logic eng_grant = 0, eng_done = 0;
    logic [1:0] eng_result = 0;
    logic [MW-1:0] wmsg = '0;
    logic eng_req, eng_hp, eng_ext, fifo_empty, fifo_full, hp_busy, ovf_flag, tx_done;
    logic [28:0] eng_id;
    logic [3:0]  eng_dlc;
    logic [63:0] eng_data;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    can_tx_sched #(.DEPTH(DEPTH)) u_can_tx_sched (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_to_hp(wr_to_hp),
        .wr_id(wmsg[97:69]), .wr_ext(wmsg[68]), .wr_dlc(wmsg[67:64]),
        .wr_data(wmsg[63:0]), .hp_abort(hp_abort),
        .eng_req(eng_req), .eng_hp(eng_hp), .eng_id(eng_id), .eng_ext(eng_ext),
        .eng_dlc(eng_dlc), .eng_data(eng_data), .eng_grant(eng_grant),
        .eng_done(eng_done), .eng_result(eng_result), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .hp_busy(hp_busy), .ovf_flag(ovf_flag),
        .tx_done(tx_done)
    );

    // Reference model state.
    logic [MW-1:0] q[$];
    logic [MW-1:0] m_hmsg;
    bit m_hpv, m_busy, m_src, m_ovf, m_done;
    bit p_req, p_busy, p_src, p_hpv;
    int p_sz;

    task automatic chk(input string tag, input logic [MW-1:0] act, input logic [MW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [MW-1:0] mk(input int k);
        return {29'(k * 7919 + 3), k[0], 4'(k % 9), {2{32'(k * 40503 + 17)}}};
    endfunction

    // Model update at each clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_hpv = 0; m_busy = 0; m_src = 0; m_ovf = 0; m_done = 0;
        end else begin
            p_busy = m_busy; p_src = m_src; p_hpv = m_hpv; p_sz = q.size();
            p_req = !m_busy && (m_hpv || q.size() != 0);
            m_done = 0;
            if (p_req && eng_grant) begin
                m_busy = 1; m_src = p_hpv;
            end else if (p_busy && eng_done) begin
                m_busy = 0;
                if (eng_result == 2'b00) begin
                    m_done = 1;
                    if (p_src) m_hpv = 0; else void'(q.pop_front());
                end
            end
            if (hp_abort && p_hpv && !(p_busy && p_src) && !(p_req && eng_grant && p_hpv))
                m_hpv = 0;
            if (wr_valid) begin
                if (wr_to_hp) begin
                    if (p_hpv) m_ovf = 1; else begin m_hpv = 1; m_hmsg = wmsg; end
                end else begin
                    if (p_sz == DEPTH) m_ovf = 1; else q.push_back(wmsg);
                end
            end
        end
    end

    // Cycle compare away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            bit e_req, e_hp;
            e_req = !m_busy && (m_hpv || q.size() != 0);
            e_hp  = m_busy ? m_src : m_hpv;
            chk("R10 eng_req", MW'(eng_req), MW'(e_req));
            chk("R4 eng_hp", MW'(eng_hp), MW'(e_hp));
            chk("R9 fifo_empty", MW'(fifo_empty), MW'(q.size() == 0));
            chk("R9 fifo_full", MW'(fifo_full), MW'(q.size() == DEPTH));
            chk("R9 hp_busy", MW'(hp_busy), MW'(m_hpv));
            chk("R3 ovf_flag", MW'(ovf_flag), MW'(m_ovf));
            chk("R7 tx_done", MW'(tx_done), MW'(m_done));
            if (e_req)
                chk("R2 offered frame", {eng_id, eng_ext, eng_dlc, eng_data},
                    e_hp ? m_hmsg : q[0]);
        end
    end

    task automatic drv(input bit v, input bit hp, input logic [MW-1:0] m,
                       input bit ab, input bit g, input bit d, input logic [1:0] r);
        @(negedge clk); #1;
        wr_valid = v; wr_to_hp = hp; wmsg = m; hp_abort = ab;
        eng_grant = g; eng_done = d; eng_result = r;
    endtask

    task automatic idle(); drv(0, 0, '0, 0, 0, 0, 2'b00); endtask
    task automatic wr(input bit hp, input int k); drv(1, hp, mk(k), 0, 0, 0, 2'b00); endtask
    task automatic grant(); drv(0, 0, '0, 0, 1, 0, 2'b00); endtask
    task automatic done(input logic [1:0] r); drv(0, 0, '0, 0, 0, 1, r); endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk("R1 reset flags", MW'({fifo_empty, fifo_full, hp_busy, ovf_flag, eng_req, tx_done}),
            MW'(6'b100000));
        #1 rst_n = 1'b1;

        // R2/R7: three queue frames in write order.
        wr(0, 1); wr(0, 2); wr(0, 3); idle();
        for (int k = 1; k <= 3; k++) begin
            chk("R2 head order", {eng_id, eng_ext, eng_dlc, eng_data}, mk(k));
            grant(); done(2'b00); idle();
            chk("R7 done pulse", MW'(tx_done), MW'(1));
        end

        // R3/R9: fill the queue and overflow it.
        for (int k = 10; k < 10 + DEPTH + 1; k++) wr(0, k);
        idle();
        chk("R9 full", MW'(fifo_full), MW'(1));
        chk("R3 overflow sticky", MW'(ovf_flag), MW'(1));

        // R5/R4: urgent frame arrives during a queue attempt.
        grant(); idle(); wr(1, 50); idle();
        chk("R5 no pre-empt", MW'(eng_req), MW'(0));
        done(2'b00); idle();
        chk("R4 urgent offered", MW'({eng_req, eng_hp}), MW'(2'b11));

        // R6: urgent retries after lost arbitration and bit error.
        grant(); done(2'b11); idle();
        chk("R6 retry arb lost", {eng_id, eng_ext, eng_dlc, eng_data}, mk(50));
        grant(); done(2'b01); idle();
        chk("R6 retry bit err", MW'({eng_req, eng_hp}), MW'(2'b11));
        grant(); done(2'b00); idle();
        chk("R9 slot freed", MW'(hp_busy), MW'(0));

        // R6: queue head retry after form error.
        grant(); done(2'b10); idle();
        chk("R6 head kept", {eng_id, eng_ext, eng_dlc, eng_data}, mk(11));

        // R8: abort before and after grant.
        wr(1, 60); idle(); drv(0, 0, '0, 1, 0, 0, 2'b00); idle();
        chk("R8 abort clears", MW'(hp_busy), MW'(0));
        wr(1, 61); grant(); drv(0, 0, '0, 1, 0, 0, 2'b00); idle();
        chk("R8 abort ignored in flight", MW'(hp_busy), MW'(1));
        done(2'b00);
        // Urgent write into occupied slot is dropped.
        wr(1, 70); wr(1, 71); idle();
        chk("R3 second urgent kept out", {eng_id, eng_ext, eng_dlc, eng_data}, mk(70));
        grant(); done(2'b00);

        // Drain queue.
        for (int k = 0; k < 8; k++) begin
            idle();
            if (eng_req) begin grant(); done(2'b00); end
        end
        idle();
        chk("R9 empty", MW'(fifo_empty), MW'(1));

        // R10: stray grant and done are ignored.
        grant(); done(2'b00); idle();
        chk("R10 stray ignored", MW'({eng_req, tx_done}), MW'(2'b00));
        idle(); idle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule